// File: doc/BRIEF.md
# Predecrement Multi-Operand Store Sequencer

This block turns a stream of bytes from a coprocessor into the memory write cycles that store a group of equal-length operands through an address register in predecrement mode. A start pulse carries the starting register value, the operand length in bytes and the number of operands. Operands go to successively lower memory regions, so the first operand ends up highest. Inside each operand, byte 0 is stored at the lowest address and the last byte at the highest.

Before each operand the working register is reduced by the operand length. The operand's region is then filled from bottom to top. The memory is organised as 32-bit long words. Each region is split into the widest aligned pieces that fit: long words where the pointer is long-word aligned, half-words at even addresses, and single bytes otherwise. Byte lanes follow big-endian placement. The byte input is paced by a ready signal and stalls whenever a write is waiting for acknowledge. When all operands are stored, a one-cycle done pulse is raised and the final register value is held until the next start.

Top module: `pdx_xfer_seq`

## Requirements
- R1: Operand k (k counted from 0 in arrival order) occupies addresses init-(k+1)*L up to init-k*L-1, so the first operand lands highest.
- R2: Within one operand, the j-th byte received (j from 0) is stored at the lowest address of its region plus j.
- R3: After completion, `final_addr` equals init minus count times L, and it stays unchanged until the next accepted start.
- R4: Each piece is a 4-byte write when the pointer's low two bits are 00 and at least 4 bytes remain. Otherwise it is a 2-byte write when the pointer is even and at least 2 bytes remain. Otherwise it is a 1-byte write.
- R5: `mem_addr` always has its low two bits at zero. The byte at address offset k (k = 0..3) travels on `mem_data[31-8k:24-8k]` with enable `mem_be[3-k]`. Bytes outside the operand regions are never written.
- R6: While `mem_wr` is high and `mem_ack` is low, the address, data and enables hold and `in_ready` is low. Every input byte is consumed exactly once, so count times L bytes are taken in total.
- R7: `done` is high for exactly one cycle. That cycle is the one right after the edge that accepted the last write.
- R8: A start with a count of zero, or a length of zero, raises `done` in the cycle after the start. It issues no write, consumes no byte, and leaves `final_addr` equal to the initial value.
- R9: A start pulse that arrives while a transfer is in progress is ignored.
- R10: Two operands of 12 bytes, starting from a long-word-aligned register, move the register down by 24 using six long-word writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| init_addr | input | AW | Register value at start |
| op_len | input | LEN_W | Operand length in bytes |
| op_cnt | input | CNT_W | Number of operands |
| in_valid | input | 1 | Coprocessor byte available |
| in_data | input | 8 | Coprocessor byte |
| in_ready | output | 1 | Byte taken when high together with in_valid |
| mem_addr | output | AW | Long-word-aligned write address |
| mem_data | output | 32 | Write data, big-endian lanes |
| mem_be | output | 4 | Byte enables, bit 3 = offset 0 |
| mem_wr | output | 1 | Write request |
| mem_ack | input | 1 | Write accepted on this edge |
| final_addr | output | AW | Register value, final after done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The done pulse is due one cycle after the edge that accepts the last write. A zero-count start raises done one cycle after the start edge. The bench records the cycle of every accepted write and of every done cycle, so both relations are checked exactly and not merely eventually. Memory contents, the number of bytes consumed and the final address are compared a few cycles after done, when no further activity may occur. Runs are repeated with input gaps and acknowledge stalls, so each result is checked both at its earliest possible cycle and under back-pressure.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  localparam int LANES = 4;
  localparam int WORD_W = 8 * LANES;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_NEXT   = 3'd1,
    ST_GATHER = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } pdx_state_e;

  typedef logic [2:0] piece_sz_t;
endpackage

// File: rtl/pdx_piece_sel.sv
module pdx_piece_sel
  import pdx_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [1:0]       ptr_lo,
  input  logic [LEN_W-1:0] rem,
  output piece_sz_t        size
);
  logic four_ok;
  logic two_ok;

  always_comb begin
    four_ok = (ptr_lo == 2'b00) && (rem >= LEN_W'(4));
    two_ok  = (ptr_lo[0] == 1'b0) && (rem >= LEN_W'(2));
    if (four_ok)     size = 3'd4;
    else if (two_ok) size = 3'd2;
    else             size = 3'd1;
  end
endmodule

// File: rtl/pdx_lane_pack.sv
module pdx_lane_pack
  import pdx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [7:0]        byte_in,
  input  piece_sz_t         size,
  input  logic [1:0]        off,
  output logic              piece_last,
  output logic [WORD_W-1:0] lane_data,
  output logic [LANES-1:0]  lane_be
);
  logic [2:0]        gcnt_q, gcnt_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [WORD_W-1:0] dmask;
  logic [LANES-1:0]  bmask;
  logic [2:0]        sh3;
  logic [1:0]        shamt;

  always_comb begin
    gcnt_d = gcnt_q;
    acc_d  = acc_q;
    if (clr) gcnt_d = 3'd0;
    else if (shift_en) gcnt_d = gcnt_q + 3'd1;
    if (shift_en) acc_d = {acc_q[WORD_W-9:0], byte_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= 3'd0;
      acc_q  <= '0;
    end else begin
      if (clr || shift_en) gcnt_q <= gcnt_d;
      if (shift_en)        acc_q  <= acc_d;
    end
  end

  always_comb begin
    piece_last = ((gcnt_q + 3'd1) == size);
    case (size)
      3'd1:    begin dmask = 32'h0000_00FF; bmask = 4'b0001; end
      3'd2:    begin dmask = 32'h0000_FFFF; bmask = 4'b0011; end
      default: begin dmask = 32'hFFFF_FFFF; bmask = 4'b1111; end
    endcase
    sh3       = 3'd4 - size - {1'b0, off};
    shamt     = sh3[1:0];
    lane_data = (acc_q & dmask) << {shamt, 3'b000};
    lane_be   = bmask << shamt;
  end
endmodule

// File: rtl/pdx_ctrl.sv
module pdx_ctrl
  import pdx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    init_addr,
  input  logic [LEN_W-1:0] op_len,
  input  logic [CNT_W-1:0] op_cnt,
  input  logic             byte_take,
  input  logic             piece_last,
  input  logic             mem_ack,
  input  piece_sz_t        size,
  output pdx_state_e       state,
  output logic [AW-1:0]    ptr,
  output logic [LEN_W-1:0] rem,
  output logic [AW-1:0]    reg_addr
);
  pdx_state_e       state_q, state_d;
  logic [AW-1:0]    addr_q, addr_d, ptr_q, ptr_d;
  logic [LEN_W-1:0] rem_q, rem_d, len_q, len_d;
  logic [CNT_W-1:0] ops_q, ops_d;
  logic [AW-1:0]    len_ext, size_ext, region_lo;
  logic             addr_en, ptr_en;

  always_comb begin
    len_ext   = {{(AW-LEN_W){1'b0}}, len_q};
    size_ext  = {{(AW-3){1'b0}}, size};
    region_lo = addr_q - len_ext;
    state_d = state_q;
    addr_d  = addr_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    len_d   = len_q;
    ops_d   = ops_q;
    addr_en = 1'b0;
    ptr_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        addr_d  = init_addr;
        len_d   = op_len;
        ops_d   = op_cnt;
        addr_en = 1'b1;
        state_d = ((op_cnt == '0) || (op_len == '0)) ? ST_DONE : ST_NEXT;
      end
      ST_NEXT: begin
        addr_d  = region_lo;
        ptr_d   = region_lo;
        rem_d   = len_q;
        ops_d   = ops_q - CNT_W'(1);
        addr_en = 1'b1;
        ptr_en  = 1'b1;
        state_d = ST_GATHER;
      end
      ST_GATHER: if (byte_take && piece_last) state_d = ST_WRITE;
      ST_WRITE: if (mem_ack) begin
        ptr_d  = ptr_q + size_ext;
        rem_d  = rem_q - LEN_W'(size);
        ptr_en = 1'b1;
        if (rem_q == LEN_W'(size)) state_d = (ops_q == '0) ? ST_DONE : ST_NEXT;
        else                       state_d = ST_GATHER;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      len_q   <= '0;
      ops_q   <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) begin
        addr_q <= addr_d;
        len_q  <= len_d;
        ops_q  <= ops_d;
      end
      if (ptr_en) begin
        ptr_q <= ptr_d;
        rem_q <= rem_d;
      end
    end
  end

  assign state    = state_q;
  assign ptr      = ptr_q;
  assign rem      = rem_q;
  assign reg_addr = addr_q;
endmodule

// File: rtl/pdx_xfer_seq.sv
module pdx_xfer_seq
  import pdx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    init_addr,
  input  logic [LEN_W-1:0] op_len,
  input  logic [CNT_W-1:0] op_cnt,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_data,
  output logic [3:0]       mem_be,
  output logic             mem_wr,
  input  logic             mem_ack,
  output logic [AW-1:0]    final_addr,
  output logic             done
);
  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  pdx_state_e       state;
  logic [AW-1:0]    ptr;
  logic [LEN_W-1:0] rem;
  piece_sz_t        size;
  logic             piece_last;
  logic             byte_take;
  logic             seq_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign in_ready  = (state == ST_GATHER);
  assign byte_take = in_ready && in_valid;
  assign mem_wr    = (state == ST_WRITE);
  assign done      = (state == ST_DONE);
  assign seq_idle  = (state == ST_IDLE);
  assign mem_addr  = {ptr[AW-1:2], 2'b00};

  pdx_piece_sel #(.LEN_W(LEN_W)) u_sel (
    .ptr_lo (ptr[1:0]),
    .rem    (rem),
    .size   (size)
  );

  pdx_lane_pack u_pack (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .clr        (mem_wr && mem_ack),
    .shift_en   (byte_take),
    .byte_in    (in_data),
    .size       (size),
    .off        (ptr[1:0]),
    .piece_last (piece_last),
    .lane_data  (mem_data),
    .lane_be    (mem_be)
  );

  pdx_ctrl #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .init_addr  (init_addr),
    .op_len     (op_len),
    .op_cnt     (op_cnt),
    .byte_take  (byte_take),
    .piece_last (piece_last),
    .mem_ack    (mem_ack),
    .size       (size),
    .state      (state),
    .ptr        (ptr),
    .rem        (rem),
    .reg_addr   (final_addr)
  );
endmodule

// File: rtl/pdx_chk.sv
module pdx_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          seq_idle,
  input logic          in_ready,
  input logic          mem_wr,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_data,
  input logic [3:0]    mem_be,
  input logic [AW-1:0] final_addr,
  input logic          done
);
  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[1:0] == 2'b00)); // R5

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_be inside {4'b1000, 4'b0100, 4'b0010, 4'b0001,
                               4'b1100, 4'b0011, 4'b1111})); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be))); // R6

  AST_NO_TAKE_IN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !in_ready); // R6

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(mem_wr && mem_ack) || $past(start && seq_idle))); // R8

  AST_FINAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !start) |=> (seq_idle && $stable(final_addr))); // R3

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && !done) |=> !seq_idle || $past(done)); // R9
endmodule

bind pdx_xfer_seq pdx_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .start      (start),
  .seq_idle   (seq_idle),
  .in_ready   (in_ready),
  .mem_wr     (mem_wr),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_data   (mem_data),
  .mem_be     (mem_be),
  .final_addr (final_addr),
  .done       (done)
);

// File: tb/sim_pdx_xfer_seq.sv
`timescale 1ns/1ps
module sim_pdx_xfer_seq;
  localparam int AW = 32;
  localparam int WBASE = 32'h0F00;
  localparam int WSIZE = 512;
  localparam int NVEC = 7;
  // {addr_lo[15:0], len[7:0], cnt[7:0], mode[7:0]}; mode bit0 input gaps, bit1 ack stalls, bit2 poke start
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h1000, 8'd12, 8'd2, 8'd0},
    {16'h1000, 8'd12, 8'd2, 8'd3},
    {16'h1003, 8'd5,  8'd3, 8'd1},
    {16'h1002, 8'd7,  8'd2, 8'd2},
    {16'h1001, 8'd1,  8'd4, 8'd3},
    {16'h1000, 8'd4,  8'd1, 8'd0},
    {16'h1006, 8'd3,  8'd2, 8'd6}
  };

  logic clk, rst_n, start, in_valid, mem_ack, in_ready, mem_wr, done;
  logic [AW-1:0] init_addr, mem_addr, final_addr;
  logic [7:0] op_len, op_cnt, in_data;
  logic [31:0] mem_data;
  logic [3:0] mem_be;

  int checks = 0, errors = 0, cyc = 0;
  int idx = 0;
  logic [2:0] mode = 3'd0;
  int wr_cnt, long_cnt, misalign_cnt, oob_cnt, done_cnt, done_cyc, ack_cyc;
  logic [7:0] mem [WSIZE];

  function automatic logic [7:0] bytev(input int g);
    return 8'((g * 7 + 3) & 255);
  endfunction

  assign in_data = bytev(idx);

  pdx_xfer_seq #(.AW(AW), .LEN_W(8), .CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init_addr(init_addr),
    .op_len(op_len), .op_cnt(op_cnt), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_be(mem_be), .mem_wr(mem_wr), .mem_ack(mem_ack),
    .final_addr(final_addr), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_valid && in_ready) idx <= idx + 1;
    in_valid <= mode[0] ? ((cyc % 3) != 0) : 1'b1;
    mem_ack  <= mode[1] ? ((cyc % 4) == 1) : 1'b1;
  end

  always @(negedge clk) begin
    if (mem_wr && mem_ack) begin
      wr_cnt <= wr_cnt + 1;
      ack_cyc <= cyc;
      if (mem_be == 4'b1111) long_cnt <= long_cnt + 1;
      if (mem_addr[1:0] != 2'b00) misalign_cnt <= misalign_cnt + 1;
      for (int k = 0; k < 4; k++) begin
        if (mem_be[3-k]) begin
          if (mem_addr + k < WBASE || mem_addr + k >= WBASE + WSIZE) oob_cnt <= oob_cnt + 1;
          else mem[mem_addr + k - WBASE] <= mem_data[31-8*k -: 8];
        end
      end
    end
    if (done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual cycle %0d expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(posedge clk); #2;
    wr_cnt = 0; long_cnt = 0; misalign_cnt = 0; oob_cnt = 0;
    done_cnt = 0; done_cyc = -1; ack_cyc = -100; idx = 0;
    for (int a = 0; a < WSIZE; a++) mem[a] = 8'hEE;
  endtask

  task automatic pulse_start(input logic [31:0] a, input logic [7:0] l, input logic [7:0] c);
    @(negedge clk);
    init_addr = a; op_len = l; op_cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input logic [39:0] v);
    logic [31:0] ia;
    int l, c, nw, nl, bad, t;
    logic [31:0] p, r, s;
    ia = {16'h0000, v[39:24]};
    l = int'(v[23:16]); c = int'(v[15:8]);
    clear_log();
    mode = v[2:0];
    pulse_start(ia, v[23:16], v[15:8]);
    t = 0;
    while (done_cnt == 0 && t < 3000) begin
      @(negedge clk);
      t++;
      if (mode[2] && t == 6) begin
        init_addr = 32'h0F40; op_len = 8'd1; op_cnt = 8'd1; start = 1'b1;
        @(negedge clk); start = 1'b0; t++;
      end
    end
    repeat (4) @(negedge clk);
    nw = 0; nl = 0;
    for (int k = 0; k < c; k++) begin
      p = ia - 32'((k + 1) * l); r = 32'(l);
      while (r > 0) begin
        if (p[1:0] == 2'b00 && r >= 4) begin s = 4; nl++; end
        else if (p[0] == 1'b0 && r >= 2) s = 2;
        else s = 1;
        nw++; p += s; r -= s;
      end
    end
    chk(final_addr == ia - 32'(c * l), "R3 final address", final_addr, ia - 32'(c * l));
    chk(mem[ia - 32'(l) - WBASE] == bytev(0), "R1 first operand at top region",
        mem[ia - 32'(l) - WBASE], bytev(0));
    chk(mem[ia - 32'(c * l) - WBASE] == bytev((c - 1) * l), "R1 last operand at bottom region",
        mem[ia - 32'(c * l) - WBASE], bytev((c - 1) * l));
    bad = 0;
    for (int a = 0; a < WSIZE; a++) begin
      logic [31:0] ad;
      int kk, jj;
      ad = 32'(WBASE + a);
      if (ad < ia && ad >= ia - 32'(c * l)) begin
        kk = int'((ia - 1 - ad) / 32'(l));
        jj = int'(ad - (ia - 32'((kk + 1) * l)));
        if (mem[a] != bytev(kk * l + jj)) bad++;
      end else if (mem[a] != 8'hEE) bad++;
    end
    chk(bad == 0, "R2 byte order in memory image", bad, 0);
    chk(misalign_cnt == 0 && oob_cnt == 0, "R5 aligned lanes and no stray write", misalign_cnt + oob_cnt, 0);
    chk(wr_cnt == nw && long_cnt == nl, "R4 piece split (writes,longs)", wr_cnt * 1000 + long_cnt, nw * 1000 + nl);
    chk(idx == c * l, "R6 bytes consumed once", idx, c * l);
    chk(done_cnt == 1 && done_cyc == ack_cyc + 1, "R7 done pulse timing", done_cyc, ack_cyc + 1);
    if (mode[2]) chk(final_addr == ia - 32'(c * l), "R9 start ignored while busy", final_addr, ia - 32'(c * l));
    if (l == 12 && c == 2 && ia[1:0] == 2'b00)
      chk(ia - final_addr == 24 && long_cnt == 6, "R10 two 12-byte operands", ia - final_addr, 24);
    repeat (6) @(negedge clk);
    chk(final_addr == ia - 32'(c * l), "R3 final address held", final_addr, ia - 32'(c * l));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; mem_ack = 1'b0;
    init_addr = '0; op_len = '0; op_cnt = '0;
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !mem_wr && !in_ready, "R7 reset state idle", {done, mem_wr, in_ready}, 0);

    for (int n = 0; n < NVEC; n++) run_case(VEC[n]);

    clear_log();
    mode = 3'd0;
    pulse_start(32'h1010, 8'd8, 8'd0);
    chk(done == 1'b1, "R8 zero count done next cycle", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(final_addr == 32'h1010 && wr_cnt == 0 && idx == 0, "R8 zero count no effect", final_addr, 32'h1010);

    clear_log();
    pulse_start(32'h1020, 8'd0, 8'd3);
    chk(done == 1'b1, "R8 zero length done next cycle", done, 1);
    repeat (3) @(negedge clk);
    chk(final_addr == 32'h1020 && wr_cnt == 0 && idx == 0, "R8 zero length no effect", final_addr, 32'h1020);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule